// File: doc/BRIEF.md
# Protected-Clock Watchdog Timer

This block is a watchdog timer for a processor subsystem. Software reloads the counter by writing a start register. If no reload arrives for a full period, the watchdog overflows and raises either an interrupt or a reset request. A small lock register gates writes to the two control registers that matter most. The first holds the reset-on-overflow choice. The second holds the count-source guard, which switches the counter onto a free-running oscillator clock.

Once the guard is set, several things change. The counter runs from the oscillator domain, so it keeps counting even if the CPU clock dies. It also keeps counting during wait and hold states. A watchdog interrupt can no longer wake the core from wait. Any request to enter stop mode is refused. The guard cannot be cleared except by reset.

The expected programming order is as follows. Open both lock bits, choose reset-on-overflow, set the guard, close both lock bits, then write the start register.

Top module: `wdog_guard`

## Requirements
- R1: Register map (bit 0 of the write data unless noted): 0 = lock, 1 = clock control, 2 = power control, 3 = sleep, 4 = start, 5 = status, 6 = count. Lock bit 0 opens the clock-control register and lock bit 1 opens the power-control register. A write to either of these registers while its lock bit is 0 leaves it unchanged.
- R2: With clock-control bit 0 (reset-on-overflow) at 1, an overflow gives exactly one single-cycle pulse on `rst_req_o`, and `irq_o` stays 0.
- R3: Power-control bit 0 (the guard) drives `osc_en_o`. Once it is set, only reset clears it, and later writes of 0 leave it at 1.
- R4: Any write to the start register, whatever its data, starts the counter from zero. A second write before overflow restarts the full period.
- R5: An overflow occurs 2**CNT_W count-clock cycles after a start. The count clock is `cpu_clk` while the guard is 0 and `osc_clk` while it is 1.
- R6: While the guard is 1, writes to sleep bit 0 are ignored and `stop_req_o` keeps its value. While the guard is 0, `stop_req_o` follows the written bit.
- R7: While the guard is 0, the counter pauses whenever `wait_i` or `hold_i` is 1. While the guard is 1, it keeps counting through both.
- R8: `wake_o` equals `irq_o` while the guard is 0 and is held at 0 while the guard is 1.
- R9: Status bit 0 is set on every overflow and cleared by writing 0 to it. Writing 1 leaves it unchanged. `irq_o` is status bit 0 when reset-on-overflow is 0.
- R10: The count register returns the current count. In guarded mode this is a value synchronized from the oscillator domain.
- R11: After reset, all registers read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock; register bus and unguarded counting |
| osc_clk | input | 1 | Free-running oscillator clock for guarded counting |
| rst | input | 1 | Synchronous active-high reset (CPU domain) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| wait_i | input | 1 | Core is in wait state |
| hold_i | input | 1 | Bus hold state active |
| osc_en_o | output | 1 | Oscillator enable, equal to the guard bit |
| stop_req_o | output | 1 | Stop-mode request bit |
| rst_req_o | output | 1 | Watchdog reset request pulse |
| irq_o | output | 1 | Watchdog interrupt request (level) |
| wake_o | output | 1 | Wait-release request from the watchdog interrupt |

## Verification
The hardest case to reach is an overflow that happens while the core sits in wait and hold with the guard set. Only then does the oscillator-domain counter, its two clock crossings and the wake suppression act together. The bench reaches it by running the full locked programming order and then raising both `wait_i` and `hold_i` before the start write. It bounds the overflow time in oscillator periods from both sides, and then checks the status, `irq_o` and `wake_o` at the ports. A smaller CNT_W keeps each period short.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

    typedef enum logic [2:0] {
        A_LOCK  = 3'd0,
        A_CLK   = 3'd1,
        A_PWR   = 3'd2,
        A_SLEEP = 3'd3,
        A_KICK  = 3'd4,
        A_STAT  = 3'd5,
        A_COUNT = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic pwr_open;
        logic clk_open;
    } lock_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/wdg_sync.sv
`timescale 1ns/1ps
module wdg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        pipe[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/wdg_cnt.sv
`timescale 1ns/1ps
module wdg_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (start) begin
                cnt <= '0;
                run <= 1'b1;
            end else if (run && en) begin
                if (cnt == TOP) begin
                    cnt <= '0;
                    ovf <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdg_regs.sv
`timescale 1ns/1ps
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ovf_evt,
    input  logic [CNT_W-1:0]  count_val,
    output logic [DATA_W-1:0] rdata,
    output lock_t             lock,
    output logic              rst_en,
    output logic              guard,
    output logic              stop_req,
    output logic              flag,
    output logic              kick
);
    reg_addr_e sel;
    assign sel  = reg_addr_e'(addr);
    assign kick = wr_en && (sel == A_KICK);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock     <= '0;
            rst_en   <= 1'b0;
            guard    <= 1'b0;
            stop_req <= 1'b0;
            flag     <= 1'b0;
        end else begin
            if (wr_en && sel == A_LOCK)
                lock <= lock_t'(wdata[1:0]);
            if (wr_en && sel == A_CLK && lock.clk_open)
                rst_en <= wdata[0];
            if (wr_en && sel == A_PWR && lock.pwr_open && wdata[0])
                guard <= 1'b1;
            if (wr_en && sel == A_SLEEP && !guard)
                stop_req <= wdata[0];
            if (ovf_evt)
                flag <= 1'b1;
            else if (wr_en && sel == A_STAT && !wdata[0])
                flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            A_LOCK:  rdata = DATA_W'(lock);
            A_CLK:   rdata = DATA_W'(rst_en);
            A_PWR:   rdata = DATA_W'(guard);
            A_SLEEP: rdata = DATA_W'(stop_req);
            A_STAT:  rdata = DATA_W'(flag);
            A_COUNT: rdata = DATA_W'(count_val);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
    import wdg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 15,
    parameter int SYNC_N = 2
) (
    input  logic              cpu_clk,
    input  logic              osc_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              wait_i,
    input  logic              hold_i,
    output logic              osc_en_o,
    output logic              stop_req_o,
    output logic              rst_req_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int XW = CNT_W + 1;

    lock_t            lock_q;
    logic             rst_en, guard, stop_req, flag, kick;
    logic             ovf_evt;
    logic [CNT_W-1:0] count_val;

    // ---------------- CPU domain ----------------
    wdg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(cpu_clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ovf_evt(ovf_evt), .count_val(count_val), .rdata(rdata),
        .lock(lock_q), .rst_en(rst_en), .guard(guard), .stop_req(stop_req),
        .flag(flag), .kick(kick)
    );

    logic [CNT_W-1:0] cpu_cnt;
    logic             cpu_ovf;

    wdg_cnt #(.CNT_W(CNT_W)) u_cpu_cnt (
        .clk(cpu_clk), .rst(rst), .start(kick && !guard),
        .en(!guard && !wait_i && !hold_i), .cnt(cpu_cnt), .ovf(cpu_ovf)
    );

    logic kick_tgl;
    always_ff @(posedge cpu_clk) begin
        if (rst)                kick_tgl <= 1'b0;
        else if (kick && guard) kick_tgl <= ~kick_tgl;
    end

    // ---------------- oscillator domain ----------------
    logic       osc_rst;
    logic [1:0] ctl_s;
    logic       kick_seen, osc_kick, osc_guard;

    wdg_sync #(.WIDTH(1), .STAGES(SYNC_N)) u_rst_sync (
        .clk(osc_clk), .d(rst), .q(osc_rst)
    );
    wdg_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_ctl_sync (
        .clk(osc_clk), .d({guard, kick_tgl}), .q(ctl_s)
    );

    assign osc_guard = ctl_s[1];
    assign osc_kick  = ctl_s[0] ^ kick_seen;

    logic [CNT_W-1:0] osc_cnt, osc_gray;
    logic             osc_ovf, ovf_tgl;

    wdg_cnt #(.CNT_W(CNT_W)) u_osc_cnt (
        .clk(osc_clk), .rst(osc_rst), .start(osc_kick && osc_guard),
        .en(osc_guard), .cnt(osc_cnt), .ovf(osc_ovf)
    );

    always_ff @(posedge osc_clk) begin
        if (osc_rst) begin
            kick_seen <= 1'b0;
            ovf_tgl   <= 1'b0;
            osc_gray  <= '0;
        end else begin
            kick_seen <= ctl_s[0];
            if (osc_ovf) ovf_tgl <= ~ovf_tgl;
            osc_gray  <= CNT_W'(to_gray(32'(osc_cnt)));
        end
    end

    // ---------------- back to CPU domain ----------------
    logic [XW-1:0] back_s;
    logic          ovf_seen, osc_ovf_evt;

    wdg_sync #(.WIDTH(XW), .STAGES(SYNC_N)) u_back_sync (
        .clk(cpu_clk), .d({ovf_tgl, osc_gray}), .q(back_s)
    );

    always_ff @(posedge cpu_clk) begin
        if (rst) ovf_seen <= 1'b0;
        else     ovf_seen <= back_s[XW-1];
    end

    assign osc_ovf_evt = back_s[XW-1] ^ ovf_seen;
    assign ovf_evt     = cpu_ovf | osc_ovf_evt;
    assign count_val   = guard ? CNT_W'(from_gray(32'(back_s[CNT_W-1:0])))
                               : cpu_cnt;

    always_ff @(posedge cpu_clk) begin
        if (rst) rst_req_o <= 1'b0;
        else     rst_req_o <= ovf_evt && rst_en;
    end

    assign irq_o      = flag && !rst_en;
    assign wake_o     = irq_o && !guard;
    assign osc_en_o   = guard;
    assign stop_req_o = stop_req;
endmodule

// File: rtl/wdog_guard_chk.sv
`timescale 1ns/1ps
module wdog_guard_chk
    import wdg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       wbit,
    input logic       clk_open,
    input logic       pwr_open,
    input logic       rst_en,
    input logic       osc_en,
    input logic       stop_req,
    input logic       rst_req,
    input logic       flag,
    input logic       wake,
    input logic       ovf_evt
);
    // R1
    clk_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CLK && !clk_open) |=> $stable(rst_en));

    // R1
    pwr_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_PWR && !pwr_open) |=> $stable(osc_en));

    // R3
    guard_hold_chk: assert property (@(posedge clk) disable iff (rst)
        osc_en |=> osc_en);

    // R6
    stop_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en && wr_en && addr == A_SLEEP) |=> $stable(stop_req));

    // R8
    wake_block_chk: assert property (@(posedge clk) disable iff (rst)
        osc_en |-> !wake);

    // R2
    req_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> flag);

    // R9
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STAT && !wbit && !ovf_evt) |=> !flag);
endmodule

bind wdog_guard wdog_guard_chk u_chk (
    .clk(cpu_clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wbit(wdata[0]),
    .clk_open(lock_q.clk_open), .pwr_open(lock_q.pwr_open), .rst_en(rst_en),
    .osc_en(osc_en_o), .stop_req(stop_req_o), .rst_req(rst_req_o),
    .flag(flag), .wake(wake_o), .ovf_evt(ovf_evt)
);

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;
    localparam int DW    = 16;
    localparam int CW    = 8;
    localparam int P     = 1 << CW;
    localparam int OSC_T = 20;

    localparam logic [2:0] LOCK = 3'd0, CLKR = 3'd1, PWR = 3'd2, SLP = 3'd3,
                           KICK = 3'd4, STAT = 3'd5, CNT = 3'd6;

    logic          cpu_clk = 1'b0, osc_clk = 1'b0, rst = 1'b1;
    logic          wr_en = 1'b0, wait_i = 1'b0, hold_i = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0, rdata;
    logic          osc_en_o, stop_req_o, rst_req_o, irq_o, wake_o;

    int total = 0, bad = 0, rq_pulses = 0;
    bit done = 1'b0;

    always #4 cpu_clk = ~cpu_clk;
    always #(OSC_T/2) osc_clk = ~osc_clk;

    always @(posedge cpu_clk) if (!rst && rst_req_o) rq_pulses++;

    wdog_guard #(.DATA_W(DW), .CNT_W(CW)) u_wdog_guard (
        .cpu_clk(cpu_clk), .osc_clk(osc_clk), .rst(rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wait_i(wait_i),
        .hold_i(hold_i), .osc_en_o(osc_en_o), .stop_req_o(stop_req_o),
        .rst_req_o(rst_req_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge cpu_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge cpu_clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output int d);
        @(negedge cpu_clk);
        addr = a;
        #1 d = int'(rdata);
    endtask

    task automatic cpu_wait(input int n);
        repeat (n) @(negedge cpu_clk);
    endtask

    task automatic t_reset;
        int v;
        for (int a = 0; a < 7; a++) begin
            reg_rd(3'(a), v);
            check("R11 reg after reset", v, 0);
        end
        check("R11 outputs after reset",
              int'({osc_en_o, stop_req_o, rst_req_o, irq_o, wake_o}), 0);
    endtask

    task automatic t_lock;
        int v;
        reg_wr(CLKR, 1); reg_rd(CLKR, v);
        check("R1 clock ctrl locked", v, 0);
        reg_wr(PWR, 1); reg_rd(PWR, v);
        check("R1 power ctrl locked", v, 0);
        check("R1 osc_en stays low", int'(osc_en_o), 0);
        reg_wr(LOCK, 1);
        reg_wr(CLKR, 1); reg_rd(CLKR, v);
        check("R1 clock ctrl opened", v, 1);
        reg_wr(PWR, 1); reg_rd(PWR, v);
        check("R1 power ctrl still locked", v, 0);
        reg_wr(CLKR, 0);
        reg_wr(LOCK, 0);
    endtask

    task automatic t_sleep_free;
        reg_wr(SLP, 1);
        check("R6 stop follows when unguarded", int'(stop_req_o), 1);
        reg_wr(SLP, 0);
        check("R6 stop cleared when unguarded", int'(stop_req_o), 0);
    endtask

    task automatic t_cpu_period;
        int v;
        reg_wr(KICK, 16'hA5A5);
        cpu_wait(9);
        reg_rd(CNT, v);
        check_rng("R10 count after 10 cycles", v, 9, 11);
        cpu_wait(P - 14);
        reg_rd(STAT, v);
        check("R5 no overflow before period", v, 0);
        cpu_wait(4);
        reg_rd(STAT, v);
        check("R5 overflow after period", v, 1);
        check("R9 irq follows flag", int'(irq_o), 1);
        check("R8 wake follows irq unguarded", int'(wake_o), 1);
        reg_wr(STAT, 1); reg_rd(STAT, v);
        check("R9 write 1 keeps flag", v, 1);
        reg_wr(STAT, 0); reg_rd(STAT, v);
        check("R9 write 0 clears flag", v, 0);
        check("R9 irq cleared", int'(irq_o), 0);
    endtask

    task automatic t_reload;
        int v;
        reg_wr(KICK, 0);
        cpu_wait(P - 20);
        reg_wr(KICK, 0);
        cpu_wait(P - 20);
        reg_rd(STAT, v);
        check("R4 reload postpones overflow", v, 0);
        cpu_wait(24);
        reg_rd(STAT, v);
        check("R4 overflow after reload period", v, 1);
        reg_wr(STAT, 0);
    endtask

    task automatic t_pause;
        int v;
        reg_wr(KICK, 0);
        wait_i = 1'b1;
        cpu_wait(P / 2);
        wait_i = 1'b0; hold_i = 1'b1;
        cpu_wait(P);
        reg_rd(STAT, v);
        check("R7 paused in wait/hold unguarded", v, 0);
        reg_rd(CNT, v);
        check_rng("R7 count frozen", v, 0, 1);
        hold_i = 1'b0;
        cpu_wait(P + 4);
        reg_rd(STAT, v);
        check("R7 resumes after release", v, 1);
        reg_wr(STAT, 0);
    endtask

    task automatic t_guarded;
        int v;
        reg_wr(LOCK, 3);
        reg_wr(CLKR, 0);
        reg_wr(PWR, 1);
        reg_wr(LOCK, 0);
        reg_wr(STAT, 0);
        check("R3 osc enabled by guard", int'(osc_en_o), 1);
        reg_wr(LOCK, 2);
        reg_wr(PWR, 0);
        reg_rd(PWR, v);
        check("R3 guard cannot be cleared", v, 1);
        reg_wr(LOCK, 0);
        reg_wr(SLP, 1);
        check("R6 stop ignored when guarded", int'(stop_req_o), 0);
        reg_rd(SLP, v);
        check("R6 sleep reg unchanged", v, 0);
        wait_i = 1'b1; hold_i = 1'b1;
        reg_wr(KICK, 0);
        reg_wr(STAT, 0);
        #(OSC_T * (P - 8));
        reg_rd(STAT, v);
        check("R5 no guarded overflow early", v, 0);
        reg_rd(CNT, v);
        check_rng("R10 guarded count advances", v, P - 20, P - 1);
        #(OSC_T * 16);
        reg_rd(STAT, v);
        check("R7 guarded overflow during wait/hold", v, 1);
        check("R9 irq in guarded mode", int'(irq_o), 1);
        check("R8 wake blocked when guarded", int'(wake_o), 0);
        wait_i = 1'b0; hold_i = 1'b0;
    endtask

    task automatic t_reset_req;
        int v, base;
        reg_wr(LOCK, 1);
        reg_wr(CLKR, 1);
        reg_wr(LOCK, 0);
        reg_rd(CLKR, v);
        check("R1 reset-on-overflow set", v, 1);
        reg_wr(KICK, 0);
        reg_wr(STAT, 0);
        base = rq_pulses;
        #(OSC_T * (P - 8));
        check("R2 no reset request early", rq_pulses - base, 0);
        #(OSC_T * 16);
        check("R2 one reset request pulse", rq_pulses - base, 1);
        check("R2 no irq with reset mode", int'(irq_o), 0);
        reg_rd(STAT, v);
        check("R9 flag set in reset mode", v, 1);
    endtask

    initial begin
        cpu_wait(20);
        rst = 1'b0;
        cpu_wait(2);
        t_reset();
        t_lock();
        t_sleep_free();
        t_cpu_period();
        t_reload();
        t_pause();
        t_guarded();
        t_reset_req();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule